// File: doc/BRIEF.md
# Multicycle Register-File Microprocessor

This block is a small programmable processor. It keeps sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. Instructions and data sit in one 256-word memory of 16-bit words, reached through a single synchronous port. A read returns data one clock after the address is presented. The processor handles seven instructions: load from a direct address, store to a direct address, store through a register pointer, load immediate, register add, register subtract, and a relative branch taken when a register is zero.

Each instruction passes through five phases of one clock each, always in the same order. The sequencer states are `PH_FETCH` (present the PC on the address bus), `PH_DECODE` (capture the returned word into the instruction register), `PH_OPERAND` (latch both source registers and present the direct address), `PH_EXECUTE` (form the result from the registers, the immediate field or the returned memory word) and `PH_STORE` (write a register or the memory, and move the PC). The transitions are fixed: `PH_FETCH`→`PH_DECODE`→`PH_OPERAND`→`PH_EXECUTE`→`PH_STORE`→`PH_FETCH`. Reset forces `PH_FETCH`. A phase that has no work for the current instruction still takes its cycle.

Top module: `mcpu_core`

## Requirements
- R1: A synchronous reset (active high) clears the PC, the instruction register and all sixteen registers. While reset is held, `mem_we` is 0 and `mem_addr` is 0. The first cycle after release fetches from address 0.
- R2: Every instruction takes exactly five cycles. A memory write from the first instruction after reset appears in cycle 4, counting the first cycle after release as cycle 0. The next instruction is fetched in cycle 5, from address PC+1.
- R3: Instruction word layout: opcode in bits [15:12], Rn select in bits [11:8], Rm select in bits [7:4]. The low byte [7:0] holds the direct address, the immediate value or the branch offset.
- R4: Opcode 0000 loads Rn with bits [7:0] of the memory word at the direct address.
- R5: Opcode 0001 writes Rn, zero-extended to 16 bits, to the direct address.
- R6: Opcode 0010 writes Rm, zero-extended to 16 bits, to the address held in Rn.
- R7: Opcode 0011 loads Rn with the 8-bit immediate.
- R8: Opcode 0100 sets Rn = Rn + Rm modulo 256.
- R9: Opcode 0101 sets Rn = Rn − Rm modulo 256.
- R10: Opcode 0110 sets PC = (address of the branch + offset) modulo 256 when Rn is zero, where the offset is two's complement. Otherwise PC = PC + 1.
- R11: Opcodes 0111 to 1111 write nothing to registers or memory and advance the PC by one.
- R12: A loop that sums 10 down to 1 into R0 leaves 55 in R0.
- R13: A store instruction asserts `mem_we` for exactly one cycle, in its fifth phase. No other instruction asserts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for fetch, operand read or store |
| mem_wdata | output | 16 | Store data, register value zero-extended |
| mem_rdata | input | 16 | Registered read data from the previous cycle's address |
| mem_we | output | 1 | Memory write enable |

## Verification
The hardest state to reach from the ports is the inside of the register file. The only path out is a store instruction. Every check therefore builds a short program in the bench memory that ends by storing the register of interest to a marked word, and then parks in a branch-to-self.

Reset clearing is shown by first running a program that dirties the registers, then resetting and storing them. The wrapping backward branch is reached by placing a branch at address 1 whose target is address 255.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int unsigned OPW = 4;

    localparam logic [OPW-1:0] OP_LDD = 4'h0;
    localparam logic [OPW-1:0] OP_STD = 4'h1;
    localparam logic [OPW-1:0] OP_STI = 4'h2;
    localparam logic [OPW-1:0] OP_LDI = 4'h3;
    localparam logic [OPW-1:0] OP_ADD = 4'h4;
    localparam logic [OPW-1:0] OP_SUB = 4'h5;
    localparam logic [OPW-1:0] OP_JZ  = 4'h6;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_DECODE,
        PH_OPERAND,
        PH_EXECUTE,
        PH_STORE
    } phase_e;

    typedef enum logic [1:0] {
        AS_PC,
        AS_DIRECT,
        AS_INDIRECT
    } addr_sel_e;

    function automatic logic op_writes_reg(input logic [OPW-1:0] op);
        return (op == OP_LDD) || (op == OP_LDI) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_writes_mem(input logic [OPW-1:0] op);
        return (op == OP_STD) || (op == OP_STI);
    endfunction

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SELW-1:0] wsel,
    input  logic [DW-1:0]   wdata,
    input  logic [SELW-1:0] rsel_a,
    output logic [DW-1:0]   rdata_a,
    input  logic [SELW-1:0] rsel_b,
    output logic [DW-1:0]   rdata_b
);

    logic [NREG-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (we && (wsel == SELW'(g))) begin
                cell_q <= wdata;
            end
        end
        assign bank[g] = cell_q;
    end

    assign rdata_a = bank[rsel_a];
    assign rdata_b = bank[rsel_b];

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic [AW-1:0]  field,
    input  logic [DW-1:0]  mem_val,
    input  logic [AW-1:0]  pc,
    output logic [DW-1:0]  result,
    output logic [AW-1:0]  pc_next
);

    logic opa_zero;

    assign opa_zero = (opa == '0);

    always_comb begin
        unique case (op)
            OP_LDD:  result = mem_val;
            OP_LDI:  result = DW'(field);
            OP_ADD:  result = opa + opb;
            OP_SUB:  result = opa - opb;
            default: result = opa;
        endcase
    end

    // the field is two's complement; modulo-2^AW addition wraps both ways
    always_comb begin
        if ((op == OP_JZ) && opa_zero) begin
            pc_next = pc + field;
        end else begin
            pc_next = pc + AW'(1);
        end
    end

endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq
    import mcpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output phase_e         phase,
    output logic           ir_load,
    output logic           opnd_load,
    output logic           res_load,
    output logic           rf_we,
    output logic           pc_load,
    output logic           mem_we,
    output addr_sel_e      addr_sel
);

    phase_e phase_q;
    phase_e phase_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next phase
    always_comb begin
        unique case (phase_q)
            PH_FETCH:   phase_d = PH_DECODE;
            PH_DECODE:  phase_d = PH_OPERAND;
            PH_OPERAND: phase_d = PH_EXECUTE;
            PH_EXECUTE: phase_d = PH_STORE;
            PH_STORE:   phase_d = PH_FETCH;
            default:    phase_d = PH_FETCH;
        endcase
    end

    // phase outputs
    always_comb begin
        ir_load   = 1'b0;
        opnd_load = 1'b0;
        res_load  = 1'b0;
        rf_we     = 1'b0;
        pc_load   = 1'b0;
        mem_we    = 1'b0;
        addr_sel  = AS_PC;
        unique case (phase_q)
            PH_FETCH: begin
                addr_sel = AS_PC;
            end
            PH_DECODE: begin
                ir_load = 1'b1;
            end
            PH_OPERAND: begin
                opnd_load = 1'b1;
                addr_sel  = AS_DIRECT;
            end
            PH_EXECUTE: begin
                res_load = 1'b1;
            end
            PH_STORE: begin
                pc_load = 1'b1;
                rf_we   = op_writes_reg(opcode);
                mem_we  = op_writes_mem(opcode);
                if (opcode == OP_STI) begin
                    addr_sel = AS_INDIRECT;
                end else if (opcode == OP_STD) begin
                    addr_sel = AS_DIRECT;
                end else begin
                    addr_sel = AS_PC;
                end
            end
            default: begin
                addr_sel = AS_PC;
            end
        endcase
    end

    assign phase = phase_q;

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int IW   = 16,
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = IW / 2
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [IW-1:0] mem_wdata,
    input  logic [IW-1:0] mem_rdata,
    output logic          mem_we
);

    localparam int SELW  = $clog2(NREG);
    localparam int RN_LO = 8;
    localparam int RM_LO = 4;

    logic [AW-1:0]  pc_q;
    logic [IW-1:0]  ir_q;
    logic [DW-1:0]  opa_q;
    logic [DW-1:0]  opb_q;
    logic [DW-1:0]  res_q;

    logic [OPW-1:0] opcode;
    logic [SELW-1:0] rn_sel;
    logic [SELW-1:0] rm_sel;
    logic [AW-1:0]  field;
    logic [DW-1:0]  rf_a;
    logic [DW-1:0]  rf_b;
    logic [DW-1:0]  alu_res;
    logic [AW-1:0]  pc_next;

    phase_e    phase_w;
    addr_sel_e addr_sel;
    logic      ir_load;
    logic      opnd_load;
    logic      res_load;
    logic      rf_we;
    logic      pc_load;

    assign opcode = ir_q[IW-1 -: OPW];
    assign rn_sel = ir_q[RN_LO +: SELW];
    assign rm_sel = ir_q[RM_LO +: SELW];
    assign field  = ir_q[AW-1:0];

    mcpu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .opcode    (opcode),
        .phase     (phase_w),
        .ir_load   (ir_load),
        .opnd_load (opnd_load),
        .res_load  (res_load),
        .rf_we     (rf_we),
        .pc_load   (pc_load),
        .mem_we    (mem_we),
        .addr_sel  (addr_sel)
    );

    mcpu_regfile #(
        .NREG (NREG),
        .DW   (DW)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .wsel    (rn_sel),
        .wdata   (res_q),
        .rsel_a  (rn_sel),
        .rdata_a (rf_a),
        .rsel_b  (rm_sel),
        .rdata_b (rf_b)
    );

    mcpu_alu #(
        .DW (DW),
        .AW (AW)
    ) u_alu (
        .op      (opcode),
        .opa     (opa_q),
        .opb     (opb_q),
        .field   (field),
        .mem_val (mem_rdata[DW-1:0]),
        .pc      (pc_q),
        .result  (alu_res),
        .pc_next (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
        end else begin
            if (ir_load) begin
                ir_q <= mem_rdata;
            end
            if (opnd_load) begin
                opa_q <= rf_a;
                opb_q <= rf_b;
            end
            if (res_load) begin
                res_q <= alu_res;
            end
            if (pc_load) begin
                pc_q <= pc_next;
            end
        end
    end

    always_comb begin
        unique case (addr_sel)
            AS_PC:       mem_addr = pc_q;
            AS_DIRECT:   mem_addr = field;
            AS_INDIRECT: mem_addr = opa_q[AW-1:0];
            default:     mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = IW'((addr_sel == AS_INDIRECT) ? opb_q : opa_q);

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk
    import mcpu_pkg::*;
#(
    parameter int AW = 8,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [AW-1:0] pc,
    input logic [IW-1:0] ir,
    input phase_e        phase
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0) && (phase == PH_FETCH) && !mem_we);

    a_r1_first_fetch: assert property (@(posedge clk)
        $fell(rst) |-> (mem_addr == '0));

    a_r2_decode_after_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));

    a_r2_fetch_after_store: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STORE) |=> (phase == PH_FETCH));

    a_r2_pc_held: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_STORE) |=> $stable(pc));

    a_r10_sequential_step: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_STORE) && (ir[IW-1 -: OPW] != OP_JZ)) |=> (pc == AW'($past(pc) + 1'b1)));

    a_r11_undefined_quiet: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_STORE) && (ir[IW-1 -: OPW] > OP_JZ)) |-> !mem_we);

    a_r13_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r13_write_phase: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_STORE));

endmodule

bind mcpu_core mcpu_core_chk #(
    .AW (AW),
    .IW (IW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .pc       (pc_q),
    .ir       (ir_q),
    .phase    (phase_w)
);

// File: tb/sim_mcpu_core.sv
module sim_mcpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;

    logic [15:0] mem [256];

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int first_we_cyc = 99;
    logic [7:0] addr_c0;
    logic [7:0] addr_c5;

    always #4 clk = ~clk;

    mcpu_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    // single-port synchronous memory
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wr_cnt == 0) first_we_cyc = cyc;
                wr_cnt = wr_cnt + 1;
            end
            if (cyc == 0) addr_c0 = mem_addr;
            if (cyc == 5) addr_c5 = mem_addr;
        end
    end

    // {opcode, Rn init, Rm init, expected Rn}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {4'h4, 8'h03, 8'h04, 8'h07},
        {4'h4, 8'hC8, 8'h64, 8'h2C},
        {4'h4, 8'hFF, 8'h01, 8'h00},
        {4'h5, 8'h0A, 8'h03, 8'h07},
        {4'h5, 8'h03, 8'h0A, 8'hF9},
        {4'h5, 8'h00, 8'h00, 8'h00},
        {4'h7, 8'h05, 8'h09, 8'h05},
        {4'hF, 8'hA5, 8'h3C, 8'hA5}
    };

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] rn, input logic [7:0] lo);
        return {op, rn, lo};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h7000;
    endtask

    task automatic start();
        rst = 1'b1;
        wr_cnt = 0;
        first_we_cyc = 99;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        // vector table: R8 add, R9 subtract, R11 undefined, R13 one write
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            mem[0] = enc(4'h3, 4'd1, VEC[v][23:16]);
            mem[1] = enc(4'h3, 4'd2, VEC[v][15:8]);
            mem[2] = enc(VEC[v][27:24], 4'd1, 8'h20);
            mem[3] = enc(4'h1, 4'd1, 8'hF0);
            mem[4] = enc(4'h6, 4'd15, 8'h00);
            mem[8'hF0] = 16'hDEAD;
            start();
            run(40);
            check(mem[8'hF0] == {8'h00, VEC[v][7:0]}, "R8/R9/R11 result", 32'(mem[8'hF0]), 32'(VEC[v][7:0]));
            check(wr_cnt == 1, "R13 write count", 32'(wr_cnt), 32'd1);
        end

        // R1 reset clears registers: dirty them first
        clear_mem();
        mem[0] = enc(4'h3, 4'd5, 8'h77);
        mem[1] = enc(4'h3, 4'd9, 8'h88);
        mem[2] = enc(4'h6, 4'd15, 8'h00);
        start();
        run(20);
        rst = 1'b1;
        run(2);
        check(mem_we == 1'b0, "R1 we in reset", 32'(mem_we), 32'd0);
        check(mem_addr == 8'h00, "R1 addr in reset", 32'(mem_addr), 32'd0);
        mem[0] = enc(4'h1, 4'd5, 8'hE0);
        mem[1] = enc(4'h1, 4'd9, 8'hE1);
        mem[8'hE0] = 16'hFFFF;
        mem[8'hE1] = 16'hFFFF;
        start();
        run(20);
        check(mem[8'hE0] == 16'h0000, "R1 R5 cleared", 32'(mem[8'hE0]), 32'd0);
        check(mem[8'hE1] == 16'h0000, "R1 R9 cleared", 32'(mem[8'hE1]), 32'd0);
        check(addr_c0 == 8'h00, "R1 first fetch", 32'(addr_c0), 32'd0);
        check(first_we_cyc == 4, "R2 write cycle", 32'(first_we_cyc), 32'd4);
        check(addr_c5 == 8'h01, "R2 second fetch", 32'(addr_c5), 32'd1);
        check(wr_cnt == 2, "R13 two stores", 32'(wr_cnt), 32'd2);

        // R4 direct load, R5 direct store, R3 field layout
        clear_mem();
        mem[0] = enc(4'h0, 4'd3, 8'h80);
        mem[1] = enc(4'h1, 4'd3, 8'h81);
        mem[2] = enc(4'h6, 4'd15, 8'h00);
        mem[8'h80] = 16'h12AB;
        start();
        run(30);
        check(mem[8'h81] == 16'h00AB, "R4/R5 load-store", 32'(mem[8'h81]), 32'h00AB);

        // R6 indirect store, R7 immediate
        clear_mem();
        mem[0] = enc(4'h3, 4'd4, 8'h90);
        mem[1] = enc(4'h3, 4'd5, 8'h5A);
        mem[2] = enc(4'h2, 4'd4, 8'h50);
        mem[3] = enc(4'h6, 4'd15, 8'h00);
        mem[8'h90] = 16'hFFFF;
        start();
        run(30);
        check(mem[8'h90] == 16'h005A, "R6/R7 indirect store", 32'(mem[8'h90]), 32'h005A);

        // R10 branch taken forward
        clear_mem();
        mem[0] = enc(4'h3, 4'd2, 8'h00);
        mem[1] = enc(4'h6, 4'd2, 8'h03);
        mem[2] = enc(4'h3, 4'd6, 8'hAA);
        mem[3] = enc(4'h1, 4'd6, 8'hA0);
        mem[4] = enc(4'h3, 4'd7, 8'h77);
        mem[5] = enc(4'h1, 4'd7, 8'hA1);
        mem[6] = enc(4'h6, 4'd15, 8'h00);
        start();
        run(60);
        check(mem[8'hA0] == 16'h7000, "R10 taken skips", 32'(mem[8'hA0]), 32'h7000);
        check(mem[8'hA1] == 16'h0077, "R10 taken target", 32'(mem[8'hA1]), 32'h0077);

        // R10 branch not taken
        mem[0] = enc(4'h3, 4'd2, 8'h01);
        start();
        run(60);
        check(mem[8'hA0] == 16'h00AA, "R10 not taken", 32'(mem[8'hA0]), 32'h00AA);

        // R10 backward branch wrapping below address 0
        clear_mem();
        mem[0] = enc(4'h3, 4'd8, 8'h3C);
        mem[1] = enc(4'h6, 4'd15, 8'hFE);
        mem[8'hFF] = enc(4'h1, 4'd8, 8'hB0);
        start();
        run(40);
        check(mem[8'hB0] == 16'h003C, "R10 wrap target", 32'(mem[8'hB0]), 32'h003C);

        // R12 summing loop
        clear_mem();
        mem[0] = enc(4'h3, 4'd0, 8'd0);
        mem[1] = enc(4'h3, 4'd1, 8'd10);
        mem[2] = enc(4'h3, 4'd2, 8'd1);
        mem[3] = enc(4'h3, 4'd3, 8'd0);
        mem[4] = enc(4'h6, 4'd1, 8'h04);
        mem[5] = enc(4'h4, 4'd0, 8'h10);
        mem[6] = enc(4'h5, 4'd1, 8'h20);
        mem[7] = enc(4'h6, 4'd3, 8'hFD);
        mem[8] = enc(4'h1, 4'd0, 8'hC0);
        mem[9] = enc(4'h6, 4'd15, 8'h00);
        start();
        run(400);
        check(mem[8'hC0] == 16'd55, "R12 loop sum", 32'(mem[8'hC0]), 32'd55);

        summary();
    end

endmodule